// File: doc/BRIEF.md
# Two-Wire Write-Only Configuration Receiver

This block receives configuration for a clock generator over a two-wire serial bus that uses start, stop and acknowledge framing. The clock line and data line are sampled in the system clock domain through a synchronizer. Start and stop conditions are the data line changing while the clock line is high. Every write is a fixed frame of eleven bytes. The first is the device address. The next two are protocol bytes whose values do not matter. Eight data bytes follow. The first six data bytes are configuration and the last two are received and dropped.

Six configuration bytes first go into shadow storage. They reach the live registers at the stop condition, and only when the address matched and all six bytes arrived. The live registers power up to defaults, so the clock generator works with no write at all. The block decodes the live bytes into an operating mode, a software frequency-select enable, a 4-bit frequency code and 40 per-output disable bits. The data line is open-drain: the block only ever pulls it low to acknowledge.

Top module: `cfg_serial_slave`

## Requirements
- R1: After reset, and with no write since, every decoded output is 0: mode 00, software select off, frequency code 0000, no output disabled.
- R2: When the address byte is 8'hD2, the block pulls the data line low during the ninth clock of each of the first eleven bytes. It does not acknowledge a twelfth or later byte.
- R3: When the address byte is anything other than 8'hD2, the block acknowledges no byte of that frame and no output changes.
- R4: The second and third bytes of the frame have no effect. The first six data bytes (frame bytes 4 to 9) become configuration bytes 0 to 5 in that order. Data bytes 6 and 7 have no effect.
- R5: Each byte is received most significant bit first. Address 8'h4B, the bit reversal of 8'hD2, is not acknowledged.
- R6: The outputs change only after a stop, and only when the matching frame delivered all six configuration bytes. A frame that stops earlier changes nothing.
- R7: Mode output = configuration byte 0 bits [1:0] (00 normal, 01 test, 10 spread, 11 all outputs high impedance).
- R8: Software select enable = configuration byte 0 bit 3. Frequency code bits [3:0] = byte 0 bits 2, 6, 5, 4 in that order, from code bit 3 down to code bit 0.
- R9: The disable vector is configuration bytes 1 to 5, with byte 1 in bits [7:0] and byte 5 in bits [39:32].
- R10: A start condition inside a frame, with no stop before it, restarts reception at the address byte and discards the configuration bytes staged so far.
- R11: A data-line change while the clock line is low is data, not a start or stop. A stop releases the data line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level as seen on the bus |
| sda_pull_o | output | 1 | 1 pulls the open-drain data line low (acknowledge) |
| mode_o | output | 2 | Operating mode field |
| sw_freq_en_o | output | 1 | Frequency comes from the software code |
| freq_code_o | output | 4 | Software frequency select code |
| out_off_o | output | 40 | Per-output disable bits, 1 = held off |

## Verification
The hardest case to reach from the ports is staged shadow data that must never commit. Two frames produce it. One is a full matching frame interrupted by a repeated start and followed by a short frame. The other is a frame that stops after only some configuration bytes. In both, the shadow bytes differ from the live ones, so a leaked commit shows up on the outputs. The stimulus comes from a bench-side open-drain bus master. It drives full, short, overlong, mismatched and bit-reversed-address frames, and it samples the acknowledge in the middle of each ninth clock.

// File: rtl/cfgs_pkg.sv
// Shared types for the serial configuration receiver.
// Assumes: one system clock that oversamples the bus by at least 8x.
package cfgs_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_BITS,
        RX_ACKWAIT,
        RX_ACK,
        RX_SKIP
    } rx_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_ev_t;
endpackage

// File: rtl/cfgs_line_sync.sv
// Synchronizes the two bus lines into the system clock domain and turns
// them into edge and condition events.
// Assumes: STAGES >= 2; lines idle high.
module cfgs_line_sync
    import cfgs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;
    logic              sda_s;

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    // Synchronizer chains, reset to the idle-high level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
    end

    // One-cycle history used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // Event decode: start/stop only while the clock line stays high.
    always_comb begin
        ev.start    = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop     = scl_s & scl_d & ~sda_d & sda_s;
        ev.scl_rise = scl_s & ~scl_d;
        ev.scl_fall = ~scl_s & scl_d;
        ev.sda      = sda_s;
    end
endmodule

// File: rtl/cfgs_frame_rx.sv
// Frame receiver: shifts bits MSB first, counts bytes, matches the address,
// generates the acknowledge and emits configuration byte writes plus a
// commit pulse on a stop that ends a complete matching frame.
// Assumes: events come from cfgs_line_sync.
module cfgs_frame_rx
    import cfgs_pkg::*;
#(
    parameter logic [7:0] DEV_ADDR = 8'hD2,
    parameter int N_LEAD = 3,
    parameter int N_CFG  = 6,
    parameter int N_TAIL = 2,
    localparam int N_BYTES = N_LEAD + N_CFG + N_TAIL,
    localparam int CNT_W   = $clog2(N_BYTES + 1),
    localparam int IDXW    = $clog2(N_CFG),
    localparam int BITW    = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_ev_t           ev,
    output logic              sda_pull,
    output logic              wr_en,
    output logic [IDXW-1:0]   wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic              commit,
    output logic              skipping
);
    localparam logic [CNT_W-1:0] LEAD_C  = CNT_W'(N_LEAD);
    localparam logic [CNT_W-1:0] CFGE_C  = CNT_W'(N_LEAD + N_CFG);
    localparam logic [CNT_W-1:0] TOTAL_C = CNT_W'(N_BYTES);
    localparam logic [BITW-1:0]  LAST_B  = BITW'(BYTE_W - 1);

    rx_state_t           state;
    logic [BYTE_W-2:0]   shift;
    logic [BITW-1:0]     bit_cnt;
    logic [CNT_W-1:0]    byte_cnt;
    logic [N_CFG-1:0]    got;
    logic                matched;
    logic [BYTE_W-1:0]   byte_now;
    logic [IDXW-1:0]     idx_now;
    logic                in_cfg;

    // Byte assembled with the bit arriving on this clock rise.
    assign byte_now = {shift, ev.sda};
    assign idx_now  = IDXW'(byte_cnt - LEAD_C);
    assign in_cfg   = (byte_cnt >= LEAD_C) && (byte_cnt < CFGE_C);
    assign skipping = (state == RX_SKIP);

    // Frame sequencer: conditions first, then bit/ack handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_IDLE;
            shift    <= '0;
            bit_cnt  <= '0;
            byte_cnt <= '0;
            got      <= '0;
            matched  <= 1'b0;
            sda_pull <= 1'b0;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
            commit   <= 1'b0;
        end else begin
            wr_en  <= 1'b0;
            commit <= 1'b0;
            if (ev.stop) begin
                commit   <= matched & (&got);
                state    <= RX_IDLE;
                sda_pull <= 1'b0;
                matched  <= 1'b0;
                got      <= '0;
            end else if (ev.start) begin
                state    <= RX_BITS;
                bit_cnt  <= '0;
                byte_cnt <= '0;
                got      <= '0;
                matched  <= 1'b0;
                sda_pull <= 1'b0;
            end else begin
                case (state)
                    RX_BITS: begin
                        if (ev.scl_rise) begin
                            shift   <= byte_now[BYTE_W-2:0];
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == LAST_B) begin
                                byte_cnt <= byte_cnt + 1'b1;
                                if (byte_cnt >= TOTAL_C) begin
                                    state <= RX_SKIP;
                                end else if (byte_cnt == '0) begin
                                    if (byte_now == DEV_ADDR) begin
                                        matched <= 1'b1;
                                        state   <= RX_ACKWAIT;
                                    end else begin
                                        state <= RX_SKIP;
                                    end
                                end else begin
                                    state <= RX_ACKWAIT;
                                    if (in_cfg) begin
                                        wr_en        <= 1'b1;
                                        wr_idx       <= idx_now;
                                        wr_data      <= byte_now;
                                        got[idx_now] <= 1'b1;
                                    end
                                end
                            end
                        end
                    end
                    RX_ACKWAIT: begin
                        if (ev.scl_fall) begin
                            sda_pull <= 1'b1;
                            state    <= RX_ACK;
                        end
                    end
                    RX_ACK: begin
                        if (ev.scl_fall) begin
                            sda_pull <= 1'b0;
                            bit_cnt  <= '0;
                            state    <= RX_BITS;
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/cfgs_reg_bank.sv
// Shadow and live configuration bytes. Writes land in shadow; commit copies
// all shadow bytes into live at once.
// Assumes: wr_idx < N_CFG whenever wr_en is high.
module cfgs_reg_bank #(
    parameter int N_CFG = 6,
    parameter logic [N_CFG*8-1:0] DEFAULTS = '0,
    localparam int IDXW = $clog2(N_CFG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDXW-1:0]   wr_idx,
    input  logic [7:0]        wr_data,
    input  logic              commit,
    output wire [N_CFG*8-1:0] live_o
);
    for (genvar i = 0; i < N_CFG; i++) begin : g_byte
        logic [7:0] sh_q;
        logic [7:0] lv_q;

        // Shadow byte: loaded by its own write strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)
                sh_q <= DEFAULTS[i*8 +: 8];
            else if (wr_en && (wr_idx == IDXW'(i)))
                sh_q <= wr_data;
        end

        // Live byte: copied from shadow on commit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lv_q <= DEFAULTS[i*8 +: 8];
            else if (commit)
                lv_q <= sh_q;
        end

        assign live_o[i*8 +: 8] = lv_q;
    end
endmodule

// File: rtl/cfg_serial_slave.sv
// Top of the write-only configuration receiver: synchronizer, frame
// receiver, register bank and field decode.
// Assumes: sda_i is the wired-AND bus level including this block's pull.
module cfg_serial_slave
    import cfgs_pkg::*;
#(
    parameter logic [7:0] DEV_ADDR = 8'hD2,
    parameter int SYNC_STAGES = 2,
    parameter int N_LEAD = 3,
    parameter int N_CFG  = 6,
    parameter int N_TAIL = 2,
    parameter logic [N_CFG*8-1:0] CFG_DEFAULTS = '0,
    localparam int IDXW  = $clog2(N_CFG),
    localparam int OFF_W = (N_CFG - 1) * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_pull_o,
    output logic [1:0]       mode_o,
    output logic             sw_freq_en_o,
    output logic [3:0]       freq_code_o,
    output logic [OFF_W-1:0] out_off_o
);
    bus_ev_t           ev;
    logic              stop_det;
    logic              wr_en;
    logic [IDXW-1:0]   wr_idx;
    logic [7:0]        wr_data;
    logic              commit;
    logic              skipping;
    wire [N_CFG*8-1:0] live;

    cfgs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    cfgs_frame_rx #(
        .DEV_ADDR (DEV_ADDR),
        .N_LEAD   (N_LEAD),
        .N_CFG    (N_CFG),
        .N_TAIL   (N_TAIL)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .sda_pull (sda_pull_o),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .commit   (commit),
        .skipping (skipping)
    );

    cfgs_reg_bank #(.N_CFG(N_CFG), .DEFAULTS(CFG_DEFAULTS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .commit  (commit),
        .live_o  (live)
    );

    assign stop_det = ev.stop;

    // Field decode from the live configuration bytes.
    always_comb begin
        mode_o       = live[1:0];
        sw_freq_en_o = live[3];
        freq_code_o  = {live[2], live[6], live[5], live[4]};
        out_off_o    = live[N_CFG*8-1:8];
    end
endmodule

// File: rtl/cfgs_checker.sv
// Protocol and commit properties of cfg_serial_slave, attached by bind.
// Assumes: signals sampled on the system clock, reset synchronous active-low.
module cfgs_checker #(
    parameter int N_CFG = 6,
    parameter int IDXW  = 3,
    parameter int OFF_W = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sda_pull_o,
    input logic             stop_det,
    input logic             commit,
    input logic             skipping,
    input logic             wr_en,
    input logic [IDXW-1:0]  wr_idx,
    input logic [1:0]       mode_o,
    input logic             sw_freq_en_o,
    input logic [3:0]       freq_code_o,
    input logic [OFF_W-1:0] out_off_o
);
    assert_commit_after_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(stop_det));

    assert_outputs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(mode_o) && $stable(sw_freq_en_o)
                     && $stable(freq_code_o) && $stable(out_off_o)));

    assert_no_ack_when_skipping_R3: assert property (@(posedge clk) disable iff (!rst_n)
        skipping |-> (!sda_pull_o && !wr_en));

    assert_write_index_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < IDXW'(N_CFG)));

    assert_release_on_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull_o);

    assert_ack_not_in_skip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !skipping);
endmodule

bind cfg_serial_slave cfgs_checker #(.N_CFG(N_CFG), .IDXW(IDXW), .OFF_W(OFF_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sda_pull_o   (sda_pull_o),
    .stop_det     (stop_det),
    .commit       (commit),
    .skipping     (skipping),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .mode_o       (mode_o),
    .sw_freq_en_o (sw_freq_en_o),
    .freq_code_o  (freq_code_o),
    .out_off_o    (out_off_o)
);

// File: tb/cfg_serial_slave_test.sv
// Bench: open-drain bus master, vector table of frames, then directed cases.
module cfg_serial_slave_test;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 8;
    localparam int NV = 7;
    localparam logic [7:0] ADDR = 8'hD2;

    // {address, data bytes 0..7 (byte 0 in the top bits), bytes sent}
    localparam logic [75:0] VEC [NV] = '{
        {8'hD2, 64'h19_A5_3C_00_FF_81_EE_77, 4'd11},
        {8'hD3, 64'h02_11_22_33_44_55_66_77, 4'd11},
        {8'hD2, 64'h03_C3_C3_00_00_00_00_00, 4'd6},
        {8'hD2, 64'h46_01_02_04_08_10_AA_BB, 4'd11},
        {8'h4B, 64'h7B_FF_FF_FF_FF_FF_00_00, 4'd11},
        {8'hD2, 64'h7B_80_40_20_10_09_5A_A5, 4'd11},
        {8'hD2, 64'h00_5A_00_A5_00_FF_00_00, 4'd9}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic sda_bus;
    logic [1:0]  mode;
    logic        sw_en;
    logic [3:0]  fcode;
    logic [39:0] off;

    int checks = 0;
    int fails = 0;
    logic done = 1'b0;
    logic [47:0] m_live = '0;

    assign sda_bus = sda_m & ~sda_pull;

    cfg_serial_slave uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_bus),
        .sda_pull_o   (sda_pull),
        .mode_o       (mode),
        .sw_freq_en_o (sw_en),
        .freq_code_o  (fcode),
        .out_off_o    (off)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q);
            scl_m = 1'b1; wq(2*Q);
            scl_m = 1'b0; wq(Q);
        end
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        ack = ~sda_bus;
        wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic frame(input logic [7:0] addr, input logic [63:0] data,
                         input int nb, input bit do_stop, output logic [11:0] acks);
        logic a;
        logic [7:0] b;
        acks = '0;
        bus_start();
        for (int i = 0; i < nb; i++) begin
            if (i == 0)      b = addr;
            else if (i == 1) b = 8'h4B;
            else if (i == 2) b = 8'hFF;
            else if (i < 11) b = data[63-(i-3)*8 -: 8];
            else             b = 8'h3C;
            send_byte(b, a);
            acks[i] = a;
        end
        if (do_stop) bus_stop();
        wq(4*Q);
    endtask

    function automatic logic [11:0] exp_acks(input logic [7:0] addr, input int nb);
        if (addr != ADDR) return '0;
        if (nb > 11) return 12'h7FF;
        return (12'(1) << nb) - 12'(1);
    endfunction

    task automatic model_commit(input logic [7:0] addr, input logic [63:0] data, input int nb);
        if (addr == ADDR && nb >= 9)
            for (int k = 0; k < 6; k++) m_live[k*8 +: 8] = data[63-k*8 -: 8];
    endtask

    task automatic check_outputs(input string where);
        chk({"R7 mode ", where}, 64'(mode), 64'(m_live[1:0]));
        chk({"R8 sw_en ", where}, 64'(sw_en), 64'(m_live[3]));
        chk({"R8 code ", where}, 64'(fcode),
            64'({m_live[2], m_live[6], m_live[5], m_live[4]}));
        chk({"R9 R4 off ", where}, 64'(off), 64'(m_live[47:8]));
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0]  va;
        logic [63:0] vd;
        logic [3:0]  vn;
        logic [11:0] acks;

        wq(5);
        rst_n = 1'b1;
        wq(5);
        // R1: defaults after reset
        chk("R1 mode", 64'(mode), 64'd0);
        chk("R1 sw_en", 64'(sw_en), 64'd0);
        chk("R1 code", 64'(fcode), 64'd0);
        chk("R1 off", 64'(off), 64'd0);
        chk("R11 idle release", 64'(sda_pull), 64'd0);

        // Vector walk: R2 R3 R5 acks, R6 commit rule, R4 byte mapping, R11 data toggles.
        for (int v = 0; v < NV; v++) begin
            {va, vd, vn} = VEC[v];
            frame(va, vd, int'(vn), 1'b1, acks);
            chk($sformatf("R2 R3 R5 acks vec%0d", v), 64'(acks), 64'(exp_acks(va, int'(vn))));
            model_commit(va, vd, int'(vn));
            check_outputs($sformatf("R6 vec%0d", v));
        end

        // R2: a twelfth byte is not acknowledged; the frame still commits.
        vd = 64'h2A_0F_F0_0F_F0_01_00_00;
        frame(ADDR, vd, 12, 1'b1, acks);
        chk("R2 overlong acks", 64'(acks), 64'(exp_acks(ADDR, 12)));
        model_commit(ADDR, vd, 12);
        check_outputs("R6 overlong");

        // R10: full frame, repeated start, short frame, stop: nothing commits.
        frame(ADDR, 64'h01_EE_EE_EE_EE_EE_00_00, 11, 1'b0, acks);
        frame(ADDR, 64'h02_00_00_00_00_00_00_00, 5, 1'b1, acks);
        chk("R10 restart acks", 64'(acks), 64'(exp_acks(ADDR, 5)));
        check_outputs("R10 restart");

        // R1: reset after configuration returns defaults.
        @(negedge clk) rst_n = 1'b0;
        wq(3);
        rst_n = 1'b1;
        wq(2);
        m_live = '0;
        check_outputs("R1 after reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule